// File: doc/BRIEF.md
# Configuration Register Access Sequencer for a Dual-Clock FIFO

This block lets a FIFO's configuration be loaded and read back over its ordinary data bus. While the active-low load input is held low, each write-enabled rising edge of the write clock stores the data word into one configuration word. Each read-enabled rising edge of the read clock copies one configuration word to the data output register. The configuration words are an almost-empty threshold, an almost-full threshold and a 12-bit control word. The write side and the read side each own a word selector that steps forward on every access and wraps. The two selectors run independently on their own clocks.

An active-low mode input is sampled while reset is held. If it is low, the extended mode is chosen: the control word joins the cycle of selectable words, and its six low bits come out of reset set. If it is high, only the two thresholds alternate and the control word stays zero. Control bit 0 enables a rewind rule. With that bit set, once load is released, the next normal FIFO transfer on a side returns that side's selector to word 0. The FIFO core reports these transfers through two pulse inputs.

Top module: `cfg_access_seq`

## Requirements
- R1: When `load_n` and `wen_n` are both low at a rising `wclk`, the low 12 bits of `din` are stored into the word chosen by the write selector, and the selector advances. When `wen_n` is high, no word changes and the write selector holds.
- R2: When `load_n` and `ren_n` are both low at a rising `rclk`, the word chosen by the read selector, zero-extended, appears on `dout` after that edge, and the read selector advances. Otherwise `dout` holds its value.
- R3: Selector codes are: word 0 is the almost-empty threshold, word 1 is the almost-full threshold, word 2 is the control word. In extended mode the order is 0, 1, 2, 0, and so on. In compatible mode it is 0, 1, 0, and so on. The two selectors step independently.
- R4: Synchronous reset returns both selectors to word 0 and clears `dout`.
- R5: If control bit 0 is 1 when `load_n` rises, the next `wr_xfer` pulse returns the write selector to word 0, and the next `rd_xfer` pulse returns the read selector to word 0. If control bit 0 is 0 at the rise, a transfer leaves the selector unchanged.
- R6: `mode_n` is sampled during reset. If it is low, the control word resets to 0x03F (bits 0 to 5 set, bits 6 to 11 clear) and can be written and read. If it is high, the control word resets to 0 and stays 0, because no access reaches it.
- R7: Both thresholds reset to 127. Each stored field is 12 bits wide, and a configuration write must carry zeros in `din` bits 17 to 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| mode_n | input | 1 | Mode select sampled in reset; low selects extended mode |
| load_n | input | 1 | Low routes accesses to configuration words |
| wen_n | input | 1 | Active-low write enable |
| ren_n | input | 1 | Active-low read enable |
| wr_xfer | input | 1 | Pulse from the FIFO core: a valid array write happened |
| rd_xfer | input | 1 | Pulse from the FIFO core: a valid array read happened |
| din | input | 18 | Data bus in |
| dout | output | 18 | Registered readback word |
| ae_thr | output | 12 | Almost-empty threshold |
| af_thr | output | 12 | Almost-full threshold |
| ctrl_word | output | 12 | Control word |

## Verification
The bench targets the wrap point in both modes. A selector that wraps at the wrong count would send the third compatible-mode write to a nonexistent control word, or would skip the control word in extended mode. It also holds `wen_n` high for several cycles with load low; a selector that drifted during those cycles would put the next write into the wrong threshold. The rewind rule is exercised both with control bit 0 set and with it cleared. An unconditional rewind, or one that ignored the transfer pulse, would land the following write and read on the wrong word. Reset is applied in both modes to catch a control word that comes up with the wrong value or can still be written when locked.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
  typedef enum logic [1:0] {
    SEL_AE   = 2'd0,
    SEL_AF   = 2'd1,
    SEL_CTRL = 2'd2
  } sel_e;

  function automatic sel_e sel_next(sel_e cur, logic ext);
    case (cur)
      SEL_AE:  return SEL_AF;
      SEL_AF:  return ext ? SEL_CTRL : SEL_AE;
      default: return SEL_AE;
    endcase
  endfunction
endpackage

// File: rtl/cfg_sel.sv
module cfg_sel
  import cfg_access_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_n,
  input  logic load_n,
  input  logic en_n,
  input  logic xfer,
  input  logic rewind_en,
  output sel_e sel,
  output logic ext
);
  logic load_prev;
  logic pend;
  logic step;
  logic rise;
  logic arm;
  logic rewind;

  assign step   = !load_n && !en_n;
  assign rise   = load_n && !load_prev;
  assign arm    = pend || (rise && rewind_en);
  assign rewind = arm && xfer;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext       <= !mode_n;
      sel       <= SEL_AE;
      load_prev <= 1'b1;
      pend      <= 1'b0;
    end else begin
      load_prev <= load_n;
      if (rewind) begin
        sel  <= SEL_AE;
        pend <= 1'b0;
      end else begin
        if (rise && rewind_en) pend <= 1'b1;
        if (step) sel <= sel_next(sel, ext);
      end
    end
  end

  p_sel_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (sel != 2'd3) && (ext || sel != SEL_CTRL));
  p_sel_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!step && !rewind) |=> $stable(sel));
  p_sel_moves_r1: assert property (@(posedge clk) disable iff (rst)
    (step && !rewind) |=> (sel != $past(sel)));
  p_rewind_r5: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (sel == SEL_AE));
  p_reset_sel_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel == SEL_AE));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_access_pkg::*;
#(
  parameter int unsigned DATA_W   = 18,
  parameter int unsigned OFS_W    = 12,
  parameter int unsigned CTRL_W   = 12,
  parameter int unsigned OFS_RST  = 127,
  parameter int unsigned EXT_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_n,
  input  logic              ext,
  input  logic              step,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] din,
  output logic [OFS_W-1:0]  ae,
  output logic [OFS_W-1:0]  af,
  output logic [CTRL_W-1:0] ctrl
);
  localparam logic [CTRL_W-1:0] CTRL_EXT_RST = CTRL_W'((1 << EXT_BITS) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ae   <= OFS_W'(OFS_RST);
      af   <= OFS_W'(OFS_RST);
      ctrl <= mode_n ? '0 : CTRL_EXT_RST;
    end else if (step) begin
      case (sel)
        SEL_AE:   ae <= din[OFS_W-1:0];
        SEL_AF:   af <= din[OFS_W-1:0];
        SEL_CTRL: if (ext) ctrl <= din[CTRL_W-1:0];
        default:  ;
      endcase
    end
  end

  p_ctrl_locked_r6: assert property (@(posedge clk) disable iff (rst)
    !ext |-> (ctrl == '0));
  p_regs_keep_r1: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(ae) && $stable(af) && $stable(ctrl)));
  p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
    step |-> (din[DATA_W-1:OFS_W] == '0));
endmodule

// File: rtl/cfg_rdback.sv
module cfg_rdback
  import cfg_access_pkg::*;
#(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned CTRL_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              ext,
  input  sel_e              sel,
  input  logic [OFS_W-1:0]  ae,
  input  logic [OFS_W-1:0]  af,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned OFS_PAD  = DATA_W - OFS_W;
  localparam int unsigned CTRL_PAD = DATA_W - CTRL_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (step) begin
      case (sel)
        SEL_AE:   dout <= {{OFS_PAD{1'b0}}, ae};
        SEL_AF:   dout <= {{OFS_PAD{1'b0}}, af};
        SEL_CTRL: if (ext) dout <= {{CTRL_PAD{1'b0}}, ctrl};
        default:  ;
      endcase
    end
  end

  p_dout_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(dout));
  p_dout_pad_r2: assert property (@(posedge clk) disable iff (rst)
    dout[DATA_W-1:OFS_W] == '0);
endmodule

// File: rtl/cfg_access_seq.sv
module cfg_access_seq
  import cfg_access_pkg::*;
#(
  parameter int unsigned DATA_W   = 18,
  parameter int unsigned OFS_W    = 12,
  parameter int unsigned CTRL_W   = 12,
  parameter int unsigned OFS_RST  = 127,
  parameter int unsigned EXT_BITS = 6
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic              mode_n,
  input  logic              load_n,
  input  logic              wen_n,
  input  logic              ren_n,
  input  logic              wr_xfer,
  input  logic              rd_xfer,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [OFS_W-1:0]  ae_thr,
  output logic [OFS_W-1:0]  af_thr,
  output logic [CTRL_W-1:0] ctrl_word
);
  localparam int unsigned SIDES  = 2;
  localparam int unsigned WR_IDX = 0;
  localparam int unsigned RD_IDX = 1;

  logic [SIDES-1:0] side_clk;
  logic [SIDES-1:0] side_en_n;
  logic [SIDES-1:0] side_xfer;
  logic [SIDES-1:0] side_ext;
  sel_e             side_sel [SIDES];

  assign side_clk  = {rclk, wclk};
  assign side_en_n = {ren_n, wen_n};
  assign side_xfer = {rd_xfer, wr_xfer};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    cfg_sel u_sel (
      .clk       (side_clk[s]),
      .rst       (rst),
      .mode_n    (mode_n),
      .load_n    (load_n),
      .en_n      (side_en_n[s]),
      .xfer      (side_xfer[s]),
      .rewind_en (ctrl_word[0]),
      .sel       (side_sel[s]),
      .ext       (side_ext[s])
    );
  end

  cfg_regs #(
    .DATA_W   (DATA_W),
    .OFS_W    (OFS_W),
    .CTRL_W   (CTRL_W),
    .OFS_RST  (OFS_RST),
    .EXT_BITS (EXT_BITS)
  ) u_regs (
    .clk    (wclk),
    .rst    (rst),
    .mode_n (mode_n),
    .ext    (side_ext[WR_IDX]),
    .step   (!load_n && !wen_n),
    .sel    (side_sel[WR_IDX]),
    .din    (din),
    .ae     (ae_thr),
    .af     (af_thr),
    .ctrl   (ctrl_word)
  );

  cfg_rdback #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .CTRL_W (CTRL_W)
  ) u_rdback (
    .clk  (rclk),
    .rst  (rst),
    .step (!load_n && !ren_n),
    .ext  (side_ext[RD_IDX]),
    .sel  (side_sel[RD_IDX]),
    .ae   (ae_thr),
    .af   (af_thr),
    .ctrl (ctrl_word),
    .dout (dout)
  );
endmodule

// File: tb/cfg_access_seq_bench.sv
module cfg_access_seq_bench;
  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_n = 1'b1;
  logic        load_n = 1'b1;
  logic        wen_n = 1'b1;
  logic        ren_n = 1'b1;
  logic        wr_xfer = 1'b0;
  logic        rd_xfer = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic [11:0] ae_thr, af_thr, ctrl_word;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [11:0] m_ae, m_af, m_ctrl;
  bit m_ext, m_wpend, m_rpend;
  int m_wsel, m_rsel;
  logic [17:0] exp_q[$];
  string tag_q[$];

  always #5 wclk = ~wclk;
  initial begin
    #2;
    forever #5 rclk = ~rclk;
  end

  cfg_access_seq u_cfg_access_seq (
    .wclk(wclk), .rclk(rclk), .rst(rst), .mode_n(mode_n), .load_n(load_n),
    .wen_n(wen_n), .ren_n(ren_n), .wr_xfer(wr_xfer), .rd_xfer(rd_xfer),
    .din(din), .dout(dout), .ae_thr(ae_thr), .af_thr(af_thr),
    .ctrl_word(ctrl_word)
  );

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] model_word(int sel);
    if (sel == 0) return m_ae;
    if (sel == 1) return m_af;
    return m_ctrl;
  endfunction

  function automatic int model_next(int sel);
    return (sel == (m_ext ? 2 : 1)) ? 0 : sel + 1;
  endfunction

  task automatic do_reset(logic mode);
    @(negedge wclk);
    mode_n = mode; rst = 1'b1; load_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1;
    repeat (3) @(negedge wclk);
    rst = 1'b0;
    m_ae = 12'd127; m_af = 12'd127;
    m_ctrl = mode ? 12'h000 : 12'h03F;
    m_ext = !mode; m_wsel = 0; m_rsel = 0; m_wpend = 0; m_rpend = 0;
    @(negedge wclk);
    load_n = 1'b0;
  endtask

  task automatic wr_cfg(logic [11:0] val);
    @(negedge wclk);
    din = {6'd0, val}; wen_n = 1'b0;
    if (m_wsel == 0) m_ae = val;
    else if (m_wsel == 1) m_af = val;
    else m_ctrl = val;
    m_wsel = model_next(m_wsel);
    @(negedge wclk);
    wen_n = 1'b1; din = '0;
  endtask

  task automatic rd_cfg(string req);
    @(negedge rclk);
    ren_n = 1'b0;
    exp_q.push_back({6'd0, model_word(m_rsel)});
    tag_q.push_back(req);
    m_rsel = model_next(m_rsel);
    @(negedge rclk);
    ren_n = 1'b1;
  endtask

  task automatic release_and_xfer();
    @(negedge wclk);
    load_n = 1'b1;
    if (m_ctrl[0]) begin m_wpend = 1; m_rpend = 1; end
    repeat (2) @(negedge wclk);
    wr_xfer = 1'b1;
    @(negedge wclk);
    wr_xfer = 1'b0;
    if (m_wpend) begin m_wsel = 0; m_wpend = 0; end
    @(negedge rclk);
    rd_xfer = 1'b1;
    @(negedge rclk);
    rd_xfer = 1'b0;
    if (m_rpend) begin m_rsel = 0; m_rpend = 0; end
    @(negedge wclk);
    load_n = 1'b0;
  endtask

  // Scoreboard monitor: every read access seen at a rising rclk is compared
  // at the following falling edge against the queued expected word.
  always @(posedge rclk) begin
    if (!rst && !load_n && !ren_n) begin
      @(negedge rclk);
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R2 actual=%h expected=<none queued>", dout);
      end else begin
        chk(tag_q.pop_front(), dout, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge wclk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    // Compatible mode reset state
    do_reset(1'b1);
    chk("R7 ae reset", {6'd0, ae_thr}, 18'd127);
    chk("R7 af reset", {6'd0, af_thr}, 18'd127);
    chk("R6 ctrl compat reset", {6'd0, ctrl_word}, 18'd0);
    chk("R4 dout reset", dout, 18'd0);

    // R3 compatible wrap: third write lands in word 0
    wr_cfg(12'h055);
    wr_cfg(12'h066);
    wr_cfg(12'h077);
    chk("R3 compat wrap ae", {6'd0, ae_thr}, 18'h077);
    chk("R1 af stored", {6'd0, af_thr}, 18'h066);
    chk("R6 ctrl locked", {6'd0, ctrl_word}, 18'd0);

    // R1 hold: load low, wen high for several cycles
    repeat (5) @(negedge wclk);
    wr_cfg(12'h0AB);
    chk("R1 hold then af", {6'd0, af_thr}, 18'h0AB);
    chk("R1 ae untouched", {6'd0, ae_thr}, 18'h077);

    // R2/R3 readback sequence in compatible mode
    rd_cfg("R3 compat rd0");
    rd_cfg("R3 compat rd1");
    rd_cfg("R3 compat rd wrap");

    // R2 hold: ren high, dout must stay
    @(negedge rclk);
    held = dout;
    repeat (4) @(negedge rclk);
    chk("R2 dout hold", dout, held);

    // Extended mode
    do_reset(1'b0);
    chk("R6 ctrl ext reset", {6'd0, ctrl_word}, 18'h03F);
    chk("R4 dout ext reset", dout, 18'd0);
    wr_cfg(12'h011);
    wr_cfg(12'h022);
    wr_cfg(12'h0C1);
    chk("R3 ext ctrl write", {6'd0, ctrl_word}, 18'h0C1);
    wr_cfg(12'h033);
    chk("R3 ext wrap ae", {6'd0, ae_thr}, 18'h033);
    rd_cfg("R3 ext rd0");
    rd_cfg("R3 ext rd1");
    rd_cfg("R3 ext rd2 ctrl");
    rd_cfg("R3 ext rd wrap");

    // R5 rewind with control bit 0 set: both selectors sit at word 1
    release_and_xfer();
    wr_cfg(12'h044);
    chk("R5 write rewound to ae", {6'd0, ae_thr}, 18'h044);
    chk("R5 af untouched", {6'd0, af_thr}, 18'h022);
    rd_cfg("R5 read rewound");

    // R5 with control bit 0 cleared: no rewind
    wr_cfg(12'h0A0);
    wr_cfg(12'h0C0);
    wr_cfg(12'h0EE);
    chk("R5 ctrl bit0 cleared", {6'd0, ctrl_word}, 18'h0C0);
    release_and_xfer();
    wr_cfg(12'h0DD);
    chk("R5 no rewind af", {6'd0, af_thr}, 18'h0DD);
    chk("R5 no rewind ae kept", {6'd0, ae_thr}, 18'h0EE);
    rd_cfg("R5 no rewind read");
    rd_cfg("R3 ext read after");

    repeat (4) @(negedge rclk);
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule